// File: doc/BRIEF.md
# Wide Command to Byte Streamer

This block accepts a fixed-width command of eleven eight-bit characters as one wide word and hands it, one character at a time, to a byte-wide serial transmitter. The command enters through a valid/ready pair: the block is ready only while idle. A word offered while ready is captured in the same clock edge. While a block is in flight, ready is low. Any valid offered then is back-pressured and never captured, so the producer must hold or repeat it until ready returns.

Each character is offered to the transmitter on an edge where the baud-derived enable is high. The offer is a one-cycle start strobe with the character on the byte output. The block then waits for the transmitter's done pulse before it waits for the next enable. Characters leave the most significant byte first, so the text goes out in reading order. A one-cycle block-done pulse marks the end of the eleventh character, and in that same cycle the block returns to idle.

Top module: `cmd_byte_streamer`

## Requirements
- R1: While reset is high and in the first cycle after it, busy, tx_start and block_done are low and load_ready is high.
- R2: A load_valid sampled high while load_ready is high captures load_data, and busy is high from the next cycle on.
- R3: The k-th start strobe of a block (k = 0..10) presents load_data[87-8k -: 8], bits [87:80] first.
- R4: tx_start is a single-cycle pulse, raised only on an edge at which baud_en was sampled high.
- R5: After a start strobe, no further start strobe occurs until tx_done has been sampled high; a tx_done arriving while no byte is outstanding has no effect.
- R6: A load_valid that arrives while busy is high (load_ready low) is ignored: the bytes of the block in flight are unchanged and no extra start strobes follow.
- R7: Each block produces exactly 11 start strobes; block_done pulses for one cycle, in the cycle after the eleventh tx_done is sampled, with busy already low.
- R8: Reset asserted in the middle of a block abandons it: busy drops, no pending start strobe is issued, and no further bytes of that block are sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | A command word is offered |
| load_ready | output | 1 | Block is idle and will accept a word |
| load_data | input | 88 | Eleven-character command, first character in [87:80] |
| baud_en | input | 1 | Baud-derived pacing enable |
| tx_byte | output | 8 | Character presented to the transmitter |
| tx_start | output | 1 | One-cycle strobe: transmit tx_byte |
| tx_done | input | 1 | Transmitter finished the current byte |
| busy | output | 1 | A block is being streamed |
| block_done | output | 1 | One-cycle pulse after the last character completes |

## Verification
A fixed ASCII command with baud_en held high checks byte order and the shortest possible hand-off timing. Random 88-bit words follow, each sent under a different baud_en density and a different transmitter latency. These separate a correct per-byte handshake from one that only works at a single pacing. Directed cases cover a load offered mid-block, which must not disturb the bytes in flight, and reset in the middle of a block, which must silence the transmitter side. A fresh block after that reset shows that the index restarts at the first character.

// File: rtl/cmd_stream_pkg.sv
package cmd_stream_pkg;
  typedef enum logic [1:0] {
    ST_IDLE      = 2'd0,
    ST_WAIT_EN   = 2'd1,
    ST_WAIT_DONE = 2'd2
  } stream_state_t;
endpackage

// File: rtl/cmd_shift_reg.sv
module cmd_shift_reg #(
  parameter int CHAR_W  = 8,
  parameter int N_CHARS = 11
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      capture,
  input  logic                      advance,
  input  logic [CHAR_W*N_CHARS-1:0] din,
  output logic [CHAR_W-1:0]         head
);
  localparam int BLK_W = CHAR_W * N_CHARS;

  logic [BLK_W-1:0] blk_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= '0;
    end else if (capture) begin
      blk_q <= din;
    end else if (advance) begin
      blk_q <= {blk_q[BLK_W-CHAR_W-1:0], {CHAR_W{1'b0}}};
    end
  end

  assign head = blk_q[BLK_W-1 -: CHAR_W];
endmodule

// File: rtl/char_counter.sv
module char_counter #(
  parameter int N_CHARS = 11
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic inc,
  output logic last
);
  localparam int IDX_W = (N_CHARS > 1) ? $clog2(N_CHARS) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CHARS - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      idx_q <= '0;
    end else if (inc && idx_q != LAST_IDX) begin
      idx_q <= idx_q + 1'b1;
    end
  end

  assign last = (idx_q == LAST_IDX);
endmodule

// File: rtl/stream_pacer.sv
module stream_pacer
  import cmd_stream_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load_valid,
  input  logic baud_en,
  input  logic tx_done,
  input  logic last,
  output logic capture,
  output logic advance,
  output logic load_ready,
  output logic tx_start,
  output logic busy,
  output logic block_done
);
  stream_state_t st_q;
  logic          start_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      start_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      start_q <= 1'b0;
      done_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (load_valid) st_q <= ST_WAIT_EN;
        end
        ST_WAIT_EN: begin
          if (baud_en) begin
            start_q <= 1'b1;
            st_q    <= ST_WAIT_DONE;
          end
        end
        ST_WAIT_DONE: begin
          if (tx_done) begin
            if (last) begin
              done_q <= 1'b1;
              st_q   <= ST_IDLE;
            end else begin
              st_q   <= ST_WAIT_EN;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign load_ready = (st_q == ST_IDLE);
  assign capture    = load_ready && load_valid;
  assign advance    = (st_q == ST_WAIT_DONE) && tx_done && !last;
  assign busy       = (st_q != ST_IDLE);
  assign tx_start   = start_q;
  assign block_done = done_q;
endmodule

// File: rtl/cmd_byte_streamer.sv
module cmd_byte_streamer #(
  parameter int CHAR_W  = 8,
  parameter int N_CHARS = 11
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      load_valid,
  output logic                      load_ready,
  input  logic [CHAR_W*N_CHARS-1:0] load_data,
  input  logic                      baud_en,
  output logic [CHAR_W-1:0]         tx_byte,
  output logic                      tx_start,
  input  logic                      tx_done,
  output logic                      busy,
  output logic                      block_done
);
  logic capture;
  logic advance;
  logic last;

  stream_pacer u_pacer (
    .clk        (clk),
    .rst        (rst),
    .load_valid (load_valid),
    .baud_en    (baud_en),
    .tx_done    (tx_done),
    .last       (last),
    .capture    (capture),
    .advance    (advance),
    .load_ready (load_ready),
    .tx_start   (tx_start),
    .busy       (busy),
    .block_done (block_done)
  );

  cmd_shift_reg #(.CHAR_W(CHAR_W), .N_CHARS(N_CHARS)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .capture (capture),
    .advance (advance),
    .din     (load_data),
    .head    (tx_byte)
  );

  char_counter #(.N_CHARS(N_CHARS)) u_count (
    .clk   (clk),
    .rst   (rst),
    .clear (capture),
    .inc   (advance),
    .last  (last)
  );
endmodule

// File: rtl/cmd_byte_streamer_chk.sv
module cmd_byte_streamer_chk #(
  parameter int N_CHARS = 11
) (
  input logic clk,
  input logic rst,
  input logic load_valid,
  input logic load_ready,
  input logic baud_en,
  input logic tx_start,
  input logic tx_done,
  input logic busy,
  input logic block_done
);
  localparam int CW = $clog2(N_CHARS + 1) + 1;

  logic          outstanding_q;
  logic [CW-1:0] starts_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      outstanding_q <= 1'b0;
      starts_q      <= '0;
    end else begin
      if (tx_start) outstanding_q <= 1'b1;
      else if (tx_done) outstanding_q <= 1'b0;
      if (load_valid && load_ready) starts_q <= '0;
      else if (tx_start) starts_q <= starts_q + 1'b1;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!busy && !tx_start && !block_done && load_ready));

  // R2
  load_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (load_valid && load_ready) |=> busy);

  // R4
  start_on_enable_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> $past(baud_en));

  // R4
  start_single_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |=> !tx_start);

  // R5
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> !outstanding_q);

  // R6
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !load_ready);

  // R7
  start_count_chk: assert property (@(posedge clk) disable iff (rst)
    tx_start |-> (starts_q < CW'(N_CHARS)));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    block_done |-> (!busy && starts_q == CW'(N_CHARS)));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    block_done |=> !block_done);
endmodule

bind cmd_byte_streamer cmd_byte_streamer_chk #(.N_CHARS(N_CHARS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .load_valid (load_valid),
  .load_ready (load_ready),
  .baud_en    (baud_en),
  .tx_start   (tx_start),
  .tx_done    (tx_done),
  .busy       (busy),
  .block_done (block_done)
);

// File: tb/cmd_byte_streamer_test.sv
module cmd_byte_streamer_test;
  localparam int NC = 11;
  localparam int BW = 8 * NC;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          load_valid = 1'b0;
  logic [BW-1:0] load_data = '0;
  logic          baud_en = 1'b0;
  logic          tx_done = 1'b0;
  logic          load_ready;
  logic [7:0]    tx_byte;
  logic          tx_start;
  logic          busy;
  logic          block_done;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  int en_pct   = 100;
  int lat_max  = 4;
  int cnt      = 0;
  bit outst    = 1'b0;
  int starts_seen = 0;
  logic [7:0] got[$];

  cmd_byte_streamer uut (
    .clk(clk), .rst(rst), .load_valid(load_valid), .load_ready(load_ready),
    .load_data(load_data), .baud_en(baud_en), .tx_byte(tx_byte),
    .tx_start(tx_start), .tx_done(tx_done), .busy(busy), .block_done(block_done)
  );

  always #5 clk = ~clk;

  function automatic logic [7:0] exp_char(logic [BW-1:0] b, int k);
    return b[BW-1-8*k -: 8];
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // transmitter model and baud pacing
  always @(negedge clk) begin
    cycles++;
    if (rst) begin
      tx_done <= 1'b0;
      baud_en <= 1'b0;
      cnt = 0;
      outst = 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (tx_start) begin
        chk(baud_en == 1'b1, "R4", "start without enable", baud_en, 1);
        chk(!outst, "R5", "start while byte outstanding", outst, 0);
        got.push_back(tx_byte);
        starts_seen++;
        outst = 1'b1;
        cnt = 2 + int'($urandom % lat_max);
      end else if (!outst && ($urandom % 7) == 0) begin
        tx_done <= 1'b1;   // stray done with nothing outstanding (R5)
      end
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          tx_done <= 1'b1;
          outst = 1'b0;
        end
      end
      baud_en <= (int'($urandom % 100) < en_pct);
    end
  end

  always @(posedge clk) begin
    if (cycles > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic send_block(logic [BW-1:0] d);
    @(negedge clk);
    chk(load_ready == 1'b1, "R2", "ready before load", load_ready, 1);
    got.delete();
    load_data  = d;
    load_valid = 1'b1;
    @(negedge clk);
    load_valid = 1'b0;
    load_data  = ~d;
    chk(busy == 1'b1, "R2", "busy after load", busy, 1);
  endtask

  task automatic wait_block(logic [BW-1:0] d, bit poke_mid);
    int dones = 0;
    int guard = 0;
    bit poked = 1'b0;
    while (dones == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (poke_mid && !poked && got.size() == 3) begin
        chk(load_ready == 1'b0, "R6", "ready while busy", load_ready, 0);
        load_data  = {BW{1'b1}} ^ d;
        load_valid = 1'b1;
        poked = 1'b1;
      end else begin
        load_valid = 1'b0;
      end
      if (block_done) begin
        dones++;
        chk(busy == 1'b0, "R7", "busy with done", busy, 0);
        chk(got.size() == NC, "R7", "bytes at done", got.size(), NC);
      end
    end
    chk(dones == 1, "R7", "done seen", dones, 1);
    @(negedge clk);
    chk(block_done == 1'b0, "R7", "done width", block_done, 0);
    chk(got.size() == NC, "R7", "byte count", got.size(), NC);
    for (int k = 0; k < NC; k++) begin
      if (k < got.size())
        chk(got[k] == exp_char(d, k), poke_mid ? "R6" : "R3", "byte value",
            got[k], exp_char(d, k));
    end
  endtask

  initial begin
    logic [BW-1:0] cmd;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    // R1
    chk(busy == 1'b0 && tx_start == 1'b0 && block_done == 1'b0, "R1",
        "outputs in reset", {busy, tx_start, block_done}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(load_ready == 1'b1 && busy == 1'b0, "R1", "idle after reset",
        {load_ready, busy}, 2'b10);

    // directed: text command, enable every cycle, short latency
    cmd = "AT+CMGR=loc";
    en_pct = 100; lat_max = 1;
    send_block(cmd);
    wait_block(cmd, 1'b0);

    // directed: load offered mid-block, sparse enable
    en_pct = 5; lat_max = 6;
    cmd = {$urandom, $urandom, $urandom};
    send_block(cmd);
    wait_block(cmd, 1'b1);

    // random blocks
    for (int b = 0; b < 20; b++) begin
      en_pct  = 10 + int'($urandom % 91);
      lat_max = 1 + int'($urandom % 8);
      cmd = {$urandom, $urandom, $urandom};
      repeat (int'($urandom % 4)) @(negedge clk);
      send_block(cmd);
      wait_block(cmd, 1'b0);
    end

    // R8: reset in the middle of a block
    en_pct = 60; lat_max = 3;
    cmd = {$urandom, $urandom, $urandom};
    send_block(cmd);
    while (got.size() < 4 && cycles < 140000) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && tx_start == 1'b0, "R8", "quiet in reset",
        {busy, tx_start}, 0);
    rst = 1'b0;
    starts_seen = 0;
    repeat (60) @(negedge clk);
    chk(starts_seen == 0, "R8", "starts after abort", starts_seen, 0);
    chk(busy == 1'b0 && load_ready == 1'b1, "R8", "idle after abort",
        {busy, load_ready}, 2'b01);

    // fresh block restarts at first character
    cmd = {$urandom, $urandom, $urandom};
    send_block(cmd);
    wait_block(cmd, 1'b0);

    finish_run();
  end
endmodule